// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for the two-wire Ethernet PHY management bus. Software writes a single 32-bit command word holding the PHY address, the register number, a read/write flag and, for writes, 16 bits of data. The block then clocks out one complete Clause 22 frame on MDC and MDIO. Accepting the command clears a finish flag, and the flag is set again when the frame has ended. For a read, the block releases the MDIO line during the turnaround. It then shifts in the 16 bits that the PHY returns and places them in a separate read-data word.

MDC is derived from the system clock through an even divisor set by a parameter. MDC stays low while the block is idle. The bidirectional MDIO pin is modelled as three signals: a value to drive, an output enable, and the sampled input. New values go onto the line only when MDC falls, so the PHY always samples a settled value on the rising edge.

Top module: `mdio_master`

## Requirements
- R1: After reset, the control word at offset 0x00 reads 0x0000_8000 and the read-data word at offset 0x04 reads 0. MDC and the MDIO output enable are both low.
- R2: A bus write to offset 0x00 while finish (control bit 15) is 1 starts a frame. Finish then reads 0 for exactly 64 x CLK_DIV system clock cycles, counted from the accepting edge, and reads 1 again afterwards. All other control-word bits read 0.
- R3: A bus write to offset 0x00 while finish is 0 is ignored: the frame in progress, its length and the read-data word are unchanged.
- R4: Every frame opens with 32 ones, then start bits 01. The opcode follows: 01 when command bit 13 is 1 (write) and 10 when it is 0 (read). Then come the PHY address from command bits 12:8 and the register number from bits 4:0, each MSB first. Command bits 14 and 7:5 have no effect on the frame.
- R5: In a write frame the turnaround is driven as 10, followed by command bits 31:16 MSB first. The output enable stays high for all 64 bit times.
- R6: In a read frame the output enable is high for the first 46 bit times and low for the last 18. The 16 bits on MDIO at the last 16 rising MDC edges form the read data, first bit in bit 15. Once finish is 1 they appear in bits 15:0 at offset 0x04, and bits 31:16 read 0.
- R7: During a frame MDC is high for CLK_DIV/2 cycles and low for CLK_DIV/2 cycles, and each frame has exactly 64 rising edges. MDC is low while idle, the output enable is low while idle, and the MDIO output changes only when MDC falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | REG_AW | Register byte offset, for both reads and writes |
| reg_wdata | input | 32 | Register write data (the command word) |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable, 1 means drive |
| mdio_i | input | 1 | Sampled MDIO pin value |

## Verification
The bench fills don't-care command bits (14, 7:5 and, for reads, 31:16) with ones. A decoder that lets them leak into the frame shows up as a corrupted address or opcode. Read responses with the first and last data bits set expose an off-by-one capture window, which would shift the word or pick up the turnaround zero. A second command is issued in the middle of a frame. A block that restarts would lengthen the frame and overwrite the read-data word. The finish-low interval and the MDC high and low widths are counted in clock cycles, so a wrong divisor or a missed bit shows up as a count that does not match.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int PRE_BITS   = 32;
   localparam int FRAME_BITS = PRE_BITS + 32;
   localparam int IDX_W      = $clog2(FRAME_BITS + 1);
   localparam int TA_FIRST   = PRE_BITS + 14;
   localparam int RD_FIRST   = PRE_BITS + 16;

   typedef struct packed {
      logic [15:0] wdata;
      logic        wr;
      logic [4:0]  phy;
      logic [4:0]  regad;
   } mdio_cmd_t;

   function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c);
      logic [31:0] tail;
      tail = {2'b01, (c.wr ? 2'b01 : 2'b10), c.phy, c.regad,
              (c.wr ? {2'b10, c.wdata} : 18'h3FFFF)};
      return {{PRE_BITS{1'b1}}, tail};
   endfunction

endpackage

// File: rtl/mdio_regdec.sv
module mdio_regdec
   import mdio_pkg::*;
#(
   parameter int AW       = 4,
   parameter int CTRL_OFS = 0,
   parameter int DATA_OFS = 4
) (
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [31:0]   reg_wdata,
   input  logic          busy,
   input  logic [15:0]   rd_data,
   output logic          start,
   output mdio_cmd_t     cmd,
   output logic [31:0]   reg_rdata
);

   localparam logic [AW-1:0] CTRL_A = AW'(CTRL_OFS);
   localparam logic [AW-1:0] DATA_A = AW'(DATA_OFS);

   if (AW < 3) begin : g_bad_aw
      $error("mdio_regdec: AW too small for offsets");
   end

   logic unused_fields;
   assign unused_fields = ^{reg_wdata[14], reg_wdata[7:5]};

   assign cmd.wdata = reg_wdata[31:16];
   assign cmd.wr    = reg_wdata[13];
   assign cmd.phy   = reg_wdata[12:8];
   assign cmd.regad = reg_wdata[4:0];

   assign start = reg_wr && (reg_addr == CTRL_A) && !busy;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == CTRL_A)
         reg_rdata[15] = !busy;
      else if (reg_addr == DATA_A)
         reg_rdata[15:0] = rd_data;
   end

endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int CLK_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_evt,
   output logic fall_evt
);

   localparam int HALF = CLK_DIV / 2;

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("mdio_clkgen: CLK_DIV must be even and at least 2");
   end

   if (HALF == 1) begin : g_toggle
      assign rise_evt = run && !mdc;
      assign fall_evt = run && mdc;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    mdc <= 1'b0;
         else if (!run) mdc <= 1'b0;
         else           mdc <= !mdc;
      end
   end else begin : g_count
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] RISE_AT = CW'(HALF - 1);
      localparam logic [CW-1:0] FALL_AT = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt;

      assign rise_evt = run && (cnt == RISE_AT);
      assign fall_evt = run && (cnt == FALL_AT);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
         end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
         end else begin
            cnt <= fall_evt ? '0 : cnt + 1'b1;
            if (rise_evt) mdc <= 1'b1;
            if (fall_evt) mdc <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
   import mdio_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  mdio_cmd_t   cmd,
   input  logic        rise_evt,
   input  logic        fall_evt,
   input  logic        mdio_i,
   output logic        busy,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic [15:0] rd_data
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
   localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_FIRST);
   localparam logic [IDX_W-1:0] RD_IDX   = IDX_W'(RD_FIRST);

   logic [FRAME_BITS-1:0] frame_sr;
   logic [IDX_W-1:0]      bit_idx;
   logic                  is_rd;
   logic [15:0]           cap_sr;

   assign mdio_o  = frame_sr[FRAME_BITS-1];
   assign mdio_oe = busy && !(is_rd && bit_idx >= TA_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         frame_sr <= '1;
         bit_idx  <= '0;
         is_rd    <= 1'b0;
         cap_sr   <= '0;
         rd_data  <= '0;
      end else if (start) begin
         busy     <= 1'b1;
         frame_sr <= build_frame(cmd);
         bit_idx  <= '0;
         is_rd    <= !cmd.wr;
      end else if (busy) begin
         if (rise_evt && is_rd && bit_idx >= RD_IDX)
            cap_sr <= {cap_sr[14:0], mdio_i};
         if (fall_evt) begin
            frame_sr <= {frame_sr[FRAME_BITS-2:0], 1'b1};
            if (bit_idx == LAST_IDX) begin
               busy <= 1'b0;
               if (is_rd) rd_data <= cap_sr;
            end else begin
               bit_idx <= bit_idx + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int CLK_DIV = 8,
   parameter int REG_AW  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   logic        busy;
   logic        start;
   logic        rise_evt;
   logic        fall_evt;
   logic [15:0] rd_data;
   mdio_cmd_t   cmd;

   mdio_regdec #(.AW(REG_AW), .CTRL_OFS(0), .DATA_OFS(4)) i_regdec (
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .busy      (busy),
      .rd_data   (rd_data),
      .start     (start),
      .cmd       (cmd),
      .reg_rdata (reg_rdata)
   );

   mdio_clkgen #(.CLK_DIV(CLK_DIV)) i_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .mdc      (mdc),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   mdio_engine i_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cmd      (cmd),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt),
      .mdio_i   (mdio_i),
      .busy     (busy),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .rd_data  (rd_data)
   );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int CLK_DIV = 8
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic start,
   input logic mdc,
   input logic mdio_o,
   input logic mdio_oe
);

   localparam int FRAME_CYC = 64 * CLK_DIV;
   int busy_cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy_cyc <= 0;
      else if (start) busy_cyc <= 0;
      else if (busy)  busy_cyc <= busy_cyc + 1;
   end

   // R7
   mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R7
   oe_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);

   // R7
   mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

   // R2
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_cyc == FRAME_CYC));

endmodule

bind mdio_master mdio_master_chk #(.CLK_DIV(CLK_DIV)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .start   (start),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;

   localparam int CLK_NS = 10;
   localparam int DIV    = 6;
   localparam int AW     = 4;
   localparam int NVEC   = 6;

   localparam logic [31:0] VEC_CMD [NVEC] = '{
      32'h1234_2100, 32'hFFFF_1F1F, 32'h8001_6AF5,
      32'h0000_5001, 32'h0000_031E, 32'h0000_2000};
   localparam logic [15:0] VEC_RSP [NVEC] = '{
      16'h0000, 16'hA5C3, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          mdc, mdio_o, mdio_oe;
   logic          mdio_i = 1'b1;

   int tests = 0;
   int fails = 0;

   logic [63:0] cap_o  = '0;
   logic [63:0] cap_oe = '0;
   int          nrise  = 0;
   int          base   = 0;
   logic [15:0] phy_resp = '0;

   mdio_master #(.CLK_DIV(DIV), .REG_AW(AW)) i_mdio_master (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   always #(CLK_NS/2) clk = !clk;

   // PHY model: record what the master drives at each rising MDC edge
   always @(posedge mdc) begin
      cap_o  <= {cap_o[62:0], mdio_o};
      cap_oe <= {cap_oe[62:0], mdio_oe};
      nrise  <= nrise + 1;
   end

   // PHY model: drive turnaround zero and read data after falling MDC
   always @(negedge mdc) begin
      int k;
      k = nrise - base;
      if (k == 47)                 mdio_i = 1'b0;
      else if (k >= 48 && k <= 63) mdio_i = phy_resp[63-k];
      else                         mdio_i = 1'b1;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_cmd(input logic [31:0] w);
      @(negedge clk);
      reg_addr = AW'(0); reg_wdata = w; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      reg_addr = AW'(0);
      #1;
      while (reg_rdata[15] == 1'b0 && n < 100000) begin
         n++;
         @(negedge clk);
         #1;
      end
   endtask

   function automatic logic [63:0] exp_frame(input logic [31:0] c);
      logic [1:0] op;
      op = c[13] ? 2'b01 : 2'b10;
      return {32'hFFFF_FFFF, 2'b01, op, c[12:8], c[4:0], 2'b10, c[31:16]};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [63:0] ef;
      int n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(AW'(0), d);
      check(d == 32'h0000_8000, "R1 ctrl", 64'(d), 64'h8000);
      rd(AW'(4), d);
      check(d == 32'h0, "R1 rdata", 64'(d), 64'h0);
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", {62'h0, mdc, mdio_oe}, 64'h0);

      // table of commands
      for (int i = 0; i < NVEC; i++) begin
         base = nrise;
         phy_resp = VEC_RSP[i];
         write_cmd(VEC_CMD[i]);
         wait_done(n);
         check(n == 64*DIV, "R2 finish-low cycles", 64'(n), 64'(64*DIV));
         check(nrise - base == 64, "R7 rising edges", 64'(nrise - base), 64'd64);
         ef = exp_frame(VEC_CMD[i]);
         rd(AW'(0), d);
         check(d == 32'h0000_8000, "R2 ctrl after done", 64'(d), 64'h8000);
         if (VEC_CMD[i][13]) begin
            // R4 header and R5 write tail
            check(cap_o == ef, "R4 R5 write frame", cap_o, ef);
            check(cap_oe == '1, "R5 oe pattern", cap_oe, '1);
         end else begin
            check(cap_o[63:18] == ef[63:18], "R4 read header",
                  64'(cap_o[63:18]), 64'(ef[63:18]));
            check(cap_oe == {{46{1'b1}}, 18'h0}, "R6 oe pattern", cap_oe,
                  {{46{1'b1}}, 18'h0});
            rd(AW'(4), d);
            check(d == {16'h0, VEC_RSP[i]}, "R6 read data", 64'(d),
                  64'(VEC_RSP[i]));
         end
      end

      // R3: command while busy is ignored
      base = nrise;
      phy_resp = 16'h1111;
      write_cmd(32'h5555_2203);
      repeat (50) @(negedge clk);
      write_cmd(32'h0000_1F00);
      rd(AW'(0), d);
      check(d == 32'h0, "R3 still busy", 64'(d), 64'h0);
      wait_done(n);
      check(nrise - base == 64, "R3 no restart", 64'(nrise - base), 64'd64);
      ef = exp_frame(32'h5555_2203);
      check(cap_o == ef, "R3 frame kept", cap_o, ef);
      rd(AW'(4), d);
      check(d == 32'h0000_FFFF, "R3 rdata kept", 64'(d), 64'hFFFF);

      // R7: MDC high and low widths
      base = nrise;
      write_cmd(32'h0000_2000);
      @(posedge mdc);
      @(negedge clk);
      n = 0;
      while (mdc) begin n++; @(negedge clk); end
      check(n == DIV/2, "R7 mdc high", 64'(n), 64'(DIV/2));
      n = 0;
      while (!mdc) begin n++; @(negedge clk); end
      check(n == DIV/2, "R7 mdc low", 64'(n), 64'(DIV/2));
      wait_done(n);
      @(negedge clk);
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R7 idle pins",
            {62'h0, mdc, mdio_oe}, 64'h0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule